// File: doc/BRIEF.md
# Dependence-Chained Issue Queue Steering Window

This block holds decoded, renamed instructions between rename and execute. Each arriving instruction carries a destination tag and up to two source tags. The block places it into one of several small in-order queues so that each consumer sits directly behind its producer. Independent instructions open a new queue. Because a queue can only release its oldest entry, readiness is judged only at the queue heads. No tag comparison is broadcast across the whole window.

A per-tag ready bit tracks which results exist. A per-tag placement record tracks which queue holds a tag's producer and whether that producer is still the youngest entry there. A result port marks tags available. One issue port releases at most one ready head per cycle, with the lowest-numbered queue winning.

Operand values, renaming, execution and recovery live elsewhere. When no legal queue exists, the input is held by dropping its ready signal.

Top module: `sw_dep_window`

## Requirements
- R1: After reset every tag reads as available, no issue is offered, and an instruction whose sources are all available is accepted.
- R2: An instruction with no waiting source (each source is either unused or available) goes to the lowest-numbered empty queue; a queue that still holds an entry, even one issuing in the same cycle, is not empty.
- R3: An instruction with a waiting source whose producer is still the youngest entry of its queue is appended to that queue.
- R4: If the producer of a waiting source is no longer the youngest entry of its queue (something was appended behind it, or it has issued), the instruction opens the lowest-numbered empty queue instead.
- R5: With two waiting sources, the first source's producer is tried first and the second source's producer next; if neither is youngest in its queue, an empty queue is opened.
- R6: The input ready output is low and nothing is written when the selected append queue already holds DEPTH entries, or when an empty queue is needed and none exists.
- R7: Only queue heads are examined; an entry behind a head whose sources are all available never issues before that head.
- R8: A head issues when each used source is available; unused source fields are ignored. A result written at a clock edge makes a waiting head issuable on the issue port right after that edge.
- R9: Accepting an instruction marks its destination tag unavailable, so its consumers wait for that tag's writeback.
- R10: At most one instruction issues per cycle; when several heads are issuable, the lowest-numbered queue wins. The issue port reports the queue number and the instruction's tags.
- R11: A queue becomes reusable as an empty queue in the cycle after its last entry issues.
- R12: An append to a queue and an issue from that same queue can happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | The presented instruction can be placed this cycle |
| in_dst | input | TAG_W | Destination tag |
| in_src1 | input | TAG_W | First source tag |
| in_src1_use | input | 1 | First source is used |
| in_src2 | input | TAG_W | Second source tag |
| in_src2_use | input | 1 | Second source is used |
| wb_valid | input | 1 | A result is written back |
| wb_tag | input | TAG_W | Tag of the written-back result |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_fifo | output | log2(NUM_Q) | Queue the issued instruction came from |
| iss_dst | output | TAG_W | Destination tag of the issued instruction |
| iss_src1 | output | TAG_W | First source tag of the issued instruction |
| iss_src2 | output | TAG_W | Second source tag of the issued instruction |

## Verification
An instruction accepted at an edge shows on the issue port immediately after that edge if its sources are available. A writeback at an edge makes a waiting head issuable right after that edge, so a consumer issues one cycle after its producer's result arrives. The input ready signal is combinational from the presented tags and the current state. The bench therefore drives inputs on the falling edge and samples every output a quarter period later, before the next rising edge. Each check sits at the step whose preceding edge applied the stimulus.

// File: rtl/sw_dep_pkg.sv
package sw_dep_pkg;

    // How the steering stage placed an instruction.
    typedef enum logic [1:0] {
        STEER_NEW  = 2'd0,
        STEER_APP1 = 2'd1,
        STEER_APP2 = 2'd2
    } steer_e;

endpackage

// File: rtl/sw_issue_fifo.sv
module sw_issue_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [W-1:0]                  push_data,
    input  logic                          pop,
    output logic [W-1:0]                  head,
    output logic [$clog2(DEPTH+1)-1:0]    occ,
    output logic                          empty,
    output logic                          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr           = bump(st_q.wr);
        end
        if (pop) begin
            st_d.rd = bump(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd];
    assign occ   = st_q.cnt;
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

endmodule

// File: rtl/sw_head_arbiter.sv
module sw_head_arbiter #(
    parameter int N = 8
) (
    input  logic [N-1:0]         req,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/sw_steer_select.sv
module sw_steer_select
    import sw_dep_pkg::*;
#(
    parameter int NUM_Q = 8
) (
    input  logic                     s1_wait,
    input  logic                     s1_tail,
    input  logic [$clog2(NUM_Q)-1:0] s1_home,
    input  logic                     s2_wait,
    input  logic                     s2_tail,
    input  logic [$clog2(NUM_Q)-1:0] s2_home,
    input  logic [NUM_Q-1:0]         q_empty,
    input  logic [NUM_Q-1:0]         q_full,
    output steer_e                   kind,
    output logic [$clog2(NUM_Q)-1:0] target,
    output logic                     ok
);
    localparam int QW = $clog2(NUM_Q);

    logic          have_free;
    logic [QW-1:0] free_idx;

    // Lowest-numbered empty queue.
    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = NUM_Q - 1; i >= 0; i--) begin
            if (q_empty[i]) begin
                have_free = 1'b1;
                free_idx  = QW'(i);
            end
        end
    end

    always_comb begin
        if (s1_wait && s1_tail) begin
            kind   = STEER_APP1;
            target = s1_home;
            ok     = !q_full[s1_home];
        end else if (s2_wait && s2_tail) begin
            kind   = STEER_APP2;
            target = s2_home;
            ok     = !q_full[s2_home];
        end else begin
            kind   = STEER_NEW;
            target = free_idx;
            ok     = have_free;
        end
    end

endmodule

// File: rtl/sw_dep_window.sv
module sw_dep_window
    import sw_dep_pkg::*;
#(
    parameter int NUM_Q = 8,
    parameter int DEPTH = 4,
    parameter int TAG_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [TAG_W-1:0]         in_dst,
    input  logic [TAG_W-1:0]         in_src1,
    input  logic                     in_src1_use,
    input  logic [TAG_W-1:0]         in_src2,
    input  logic                     in_src2_use,
    input  logic                     wb_valid,
    input  logic [TAG_W-1:0]         wb_tag,
    output logic                     iss_valid,
    output logic [$clog2(NUM_Q)-1:0] iss_fifo,
    output logic [TAG_W-1:0]         iss_dst,
    output logic [TAG_W-1:0]         iss_src1,
    output logic [TAG_W-1:0]         iss_src2
);
    localparam int QW   = $clog2(NUM_Q);
    localparam int CW   = $clog2(DEPTH+1);
    localparam int NTAG = 1 << TAG_W;

    typedef struct packed {
        logic [TAG_W-1:0] dst;
        logic [TAG_W-1:0] s1;
        logic             s1u;
        logic [TAG_W-1:0] s2;
        logic             s2u;
    } entry_t;

    localparam int EW = $bits(entry_t);

    // Per-tag tables: result available, producer youngest in its queue,
    // and the queue that holds the producer.
    typedef struct packed {
        logic [NTAG-1:0]         rdy;
        logic [NTAG-1:0]         tail;
        logic [NTAG-1:0][QW-1:0] home;
    } tbl_t;

    tbl_t tbl_q, tbl_d;

    logic [NUM_Q-1:0][EW-1:0] head_raw;
    logic [NUM_Q-1:0][CW-1:0] occ;
    logic [NUM_Q-1:0]         q_empty;
    logic [NUM_Q-1:0]         q_full;
    logic [NUM_Q-1:0]         hready;
    logic [NUM_Q-1:0]         push_vec;
    logic [NUM_Q-1:0]         pop_vec;
    entry_t                   in_ent;
    entry_t                   iss_ent;
    steer_e                   kind;
    logic [QW-1:0]            target;
    logic                     steer_ok;
    logic                     accept;
    logic                     gnt_any;
    logic [QW-1:0]            gnt_idx;

    assign in_ent = '{dst: in_dst, s1: in_src1, s1u: in_src1_use,
                      s2: in_src2, s2u: in_src2_use};

    sw_steer_select #(.NUM_Q(NUM_Q)) u_steer (
        .s1_wait (in_src1_use && !tbl_q.rdy[in_src1]),
        .s1_tail (tbl_q.tail[in_src1]),
        .s1_home (tbl_q.home[in_src1]),
        .s2_wait (in_src2_use && !tbl_q.rdy[in_src2]),
        .s2_tail (tbl_q.tail[in_src2]),
        .s2_home (tbl_q.home[in_src2]),
        .q_empty (q_empty),
        .q_full  (q_full),
        .kind    (kind),
        .target  (target),
        .ok      (steer_ok)
    );

    assign in_ready = steer_ok;
    assign accept   = in_valid && steer_ok;

    generate
        for (genvar g = 0; g < NUM_Q; g++) begin : g_q
            entry_t hd;
            assign push_vec[g] = accept && (target == QW'(g));
            assign pop_vec[g]  = gnt_any && (gnt_idx == QW'(g));

            sw_issue_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (push_vec[g]),
                .push_data (in_ent),
                .pop       (pop_vec[g]),
                .head      (head_raw[g]),
                .occ       (occ[g]),
                .empty     (q_empty[g]),
                .full      (q_full[g])
            );

            assign hd = entry_t'(head_raw[g]);
            assign hready[g] = !q_empty[g]
                             && (!hd.s1u || tbl_q.rdy[hd.s1])
                             && (!hd.s2u || tbl_q.rdy[hd.s2]);
        end
    endgenerate

    sw_head_arbiter #(.N(NUM_Q)) u_arb (
        .req (hready),
        .any (gnt_any),
        .idx (gnt_idx)
    );

    assign iss_ent   = entry_t'(head_raw[gnt_idx]);
    assign iss_valid = gnt_any;
    assign iss_fifo  = gnt_idx;
    assign iss_dst   = iss_ent.dst;
    assign iss_src1  = iss_ent.s1;
    assign iss_src2  = iss_ent.s2;

    always_comb begin
        tbl_d = tbl_q;
        if (wb_valid) begin
            tbl_d.rdy[wb_tag] = 1'b1;
        end
        if (gnt_any) begin
            tbl_d.tail[iss_ent.dst] = 1'b0;
        end
        if (accept) begin
            if (kind == STEER_APP1) tbl_d.tail[in_src1] = 1'b0;
            if (kind == STEER_APP2) tbl_d.tail[in_src2] = 1'b0;
            tbl_d.rdy[in_dst]  = 1'b0;
            tbl_d.tail[in_dst] = 1'b1;
            tbl_d.home[in_dst] = target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q      <= '0;
            tbl_q.rdy  <= '1;
        end else begin
            tbl_q <= tbl_d;
        end
    end

endmodule

// File: rtl/sw_dep_window_chk.sv
module sw_dep_window_chk #(
    parameter int NUM_Q = 8,
    parameter int DEPTH = 4,
    parameter int TAG_W = 6
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  in_valid,
    input logic                                  in_ready,
    input logic [TAG_W-1:0]                      in_dst,
    input logic                                  iss_valid,
    input logic [$clog2(NUM_Q)-1:0]              iss_fifo,
    input logic [NUM_Q-1:0]                      hready,
    input logic [NUM_Q-1:0]                      push_vec,
    input logic [NUM_Q-1:0]                      pop_vec,
    input logic [NUM_Q-1:0][$clog2(DEPTH+1)-1:0] occ,
    input logic [(1<<TAG_W)-1:0]                 rdy
);
    localparam int CW = $clog2(DEPTH+1);

    logic [NUM_Q-1:0] below_mask;
    assign below_mask = (NUM_Q'(1) << iss_fifo) - NUM_Q'(1);

    p_single_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_vec));

    p_lowest_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> ((hready & below_mask) == '0));

    p_stall_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (push_vec == '0));

    p_write_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vec != '0) |-> in_valid);

    p_dst_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !rdy[$past(in_dst)]);

    generate
        for (genvar g = 0; g < NUM_Q; g++) begin : g_occ
            p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
                occ[g] <= CW'(DEPTH));
        end
    endgenerate

endmodule

bind sw_dep_window sw_dep_window_chk #(
    .NUM_Q (NUM_Q),
    .DEPTH (DEPTH),
    .TAG_W (TAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_dst    (in_dst),
    .iss_valid (iss_valid),
    .iss_fifo  (iss_fifo),
    .hready    (hready),
    .push_vec  (push_vec),
    .pop_vec   (pop_vec),
    .occ       (occ),
    .rdy       (tbl_q.rdy)
);

// File: tb/test_sw_dep_window.sv
module test_sw_dep_window;
    localparam int NQ = 8;
    localparam int DP = 4;
    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [TW-1:0] in_dst = '0;
    logic [TW-1:0] in_src1 = '0;
    logic          in_src1_use = 1'b0;
    logic [TW-1:0] in_src2 = '0;
    logic          in_src2_use = 1'b0;
    logic          wb_valid = 1'b0;
    logic [TW-1:0] wb_tag = '0;
    logic          iss_valid;
    logic [2:0]    iss_fifo;
    logic [TW-1:0] iss_dst;
    logic [TW-1:0] iss_src1;
    logic [TW-1:0] iss_src2;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sw_dep_window #(.NUM_Q(NQ), .DEPTH(DP), .TAG_W(TW)) i_sw_dep_window (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_dst(in_dst), .in_src1(in_src1), .in_src1_use(in_src1_use),
        .in_src2(in_src2), .in_src2_use(in_src2_use),
        .wb_valid(wb_valid), .wb_tag(wb_tag),
        .iss_valid(iss_valid), .iss_fifo(iss_fifo),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2)
    );

    // Drive on the falling edge, sample 5 ns later (before the rising edge).
    task automatic step(input bit v, input int d, input int s1, input bit u1,
                        input int s2, input bit u2, input bit wv, input int wt);
        @(negedge clk);
        in_valid    = v;
        in_dst      = TW'(d);
        in_src1     = TW'(s1);
        in_src1_use = u1;
        in_src2     = TW'(s2);
        in_src2_use = u2;
        wb_valid    = wv;
        wb_tag      = TW'(wt);
        #5;
    endtask

    task automatic put(input int d, input int s1, input bit u1, input int s2, input bit u2);
        step(1'b1, d, s1, u1, s2, u2, 1'b0, 0);
    endtask

    task automatic idle();
        step(1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 0);
    endtask

    task automatic wbk(input int t);
        step(1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b1, t);
    endtask

    task automatic ck_iss(input bit ev, input int ed, input int ef, input string r);
        n_chk++;
        if (iss_valid !== ev || (ev && (iss_dst !== TW'(ed) || iss_fifo !== 3'(ef)))) begin
            n_bad++;
            $display("FAIL %s: issue v=%0b dst=%0d fifo=%0d, expected v=%0b dst=%0d fifo=%0d",
                     r, iss_valid, iss_dst, iss_fifo, ev, ed, ef);
        end
    endtask

    task automatic ck_rdy(input bit e, input string r);
        n_chk++;
        if (in_ready !== e) begin
            n_bad++;
            $display("FAIL %s: in_ready=%0b, expected %0b", r, in_ready, e);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; wb_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        idle();                     ck_iss(1'b0, 0, 0, "R1");
        put(1, 63, 1, 62, 1);       ck_rdy(1'b1, "R1");
        idle();                     ck_iss(1'b1, 1, 0, "R1");
    endtask

    // R2: independent instructions open the lowest empty queue
    task automatic t_new_chain();
        do_reset();
        put(1, 0, 0, 0, 0);
        put(2, 5, 1, 0, 0);         ck_iss(1'b1, 1, 0, "R2");
        idle();                     ck_iss(1'b1, 2, 1, "R2");
    endtask

    // R3, R9, R8, R12: append behind producer issuing in the same cycle
    task automatic t_append();
        do_reset();
        put(10, 3, 1, 0, 0);        ck_iss(1'b0, 0, 0, "R1");
        put(11, 10, 1, 0, 0);       ck_iss(1'b1, 10, 0, "R12"); ck_rdy(1'b1, "R12");
        wbk(10);                    ck_iss(1'b0, 0, 0, "R9");
        idle();                     ck_iss(1'b1, 11, 0, "R3");
    endtask

    // R4: producer no longer youngest opens a new queue
    task automatic t_not_tail();
        do_reset();
        put(20, 0, 0, 0, 0);
        put(21, 20, 1, 0, 0);       ck_iss(1'b1, 20, 0, "R3");
        put(22, 21, 1, 0, 0);       ck_iss(1'b0, 0, 0, "R9");
        put(23, 21, 1, 0, 0);       ck_iss(1'b0, 0, 0, "R9");
        wbk(20);                    ck_iss(1'b0, 0, 0, "R8");
        wbk(21);                    ck_iss(1'b1, 21, 0, "R8");
        idle();                     ck_iss(1'b1, 22, 0, "R10");
        idle();                     ck_iss(1'b1, 23, 1, "R4");
    endtask

    // R5: two waiting sources, first then second then new
    task automatic t_two_src();
        do_reset();
        put(50, 0, 0, 0, 0);
        put(30, 50, 1, 0, 0);       ck_iss(1'b1, 50, 0, "R8");
        put(31, 50, 1, 0, 0);       ck_iss(1'b0, 0, 0, "R4");
        put(32, 30, 1, 31, 1);
        put(33, 30, 1, 31, 1);
        step(1'b1, 34, 30, 1'b1, 31, 1'b1, 1'b1, 50);
        ck_iss(1'b0, 0, 0, "R5");
        wbk(30);                    ck_iss(1'b1, 30, 0, "R10");
        wbk(31);                    ck_iss(1'b1, 31, 1, "R4");
        idle();                     ck_iss(1'b1, 32, 0, "R5");
        idle();                     ck_iss(1'b1, 33, 1, "R5");
        idle();                     ck_iss(1'b1, 34, 2, "R5");
    endtask

    // R6: full append target stalls
    task automatic t_full();
        do_reset();
        put(50, 0, 0, 0, 0);
        idle();                     ck_iss(1'b1, 50, 0, "R8");
        put(60, 50, 1, 0, 0);
        put(61, 60, 1, 0, 0);
        put(62, 61, 1, 0, 0);
        put(63, 62, 1, 0, 0);
        put(5, 63, 1, 0, 0);        ck_rdy(1'b0, "R6");
        ck_iss(1'b0, 0, 0, "R6");
        idle();
    endtask

    // R6, R11: no empty queue stalls; freed queue reused
    task automatic t_no_empty();
        do_reset();
        put(50, 0, 0, 0, 0);
        idle();
        for (int i = 0; i < NQ; i++) put(10 + i, 50, 1, 0, 0);
        put(19, 0, 0, 0, 0);        ck_rdy(1'b0, "R6");
        step(1'b1, 19, 0, 1'b0, 0, 1'b0, 1'b1, 50);
        ck_rdy(1'b0, "R6");         ck_iss(1'b0, 0, 0, "R6");
        put(19, 0, 0, 0, 0);        ck_iss(1'b1, 10, 0, "R10"); ck_rdy(1'b0, "R11");
        put(19, 0, 0, 0, 0);        ck_rdy(1'b1, "R11"); ck_iss(1'b1, 11, 1, "R10");
        idle();                     ck_iss(1'b1, 19, 0, "R11");
        idle();                     ck_iss(1'b1, 12, 2, "R10");
    endtask

    // R7: ready entry behind a waiting head does not issue
    task automatic t_head_only();
        do_reset();
        put(50, 0, 0, 0, 0);
        idle();
        put(60, 50, 1, 0, 0);
        put(61, 60, 1, 0, 0);
        wbk(60);
        wbk(50);                    ck_iss(1'b0, 0, 0, "R7");
        idle();                     ck_iss(1'b1, 60, 0, "R7");
        idle();                     ck_iss(1'b1, 61, 0, "R7");
    endtask

    // R8: unused source fields are ignored
    task automatic t_unused();
        do_reset();
        put(50, 0, 0, 0, 0);
        idle();
        put(7, 50, 0, 50, 0);       ck_rdy(1'b1, "R8");
        idle();                     ck_iss(1'b1, 7, 0, "R8");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_new_chain();
        t_append();
        t_not_tail();
        t_two_src();
        t_full();
        t_no_empty();
        t_head_only();
        t_unused();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule